// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block is a clock-synchronous model of the command state machine found in a bytewide parallel NOR flash. It watches the host bus for write cycles and recognises the unlock-protected command sequences: return to read, identifier mode, byte program, whole-array erase and sector erase. It tracks which mode the device is in. During a sector erase it gathers a mask of selected sectors inside a retriggerable acceptance window. When a sequence completes, it sends a one-cycle start request (address, data or sector mask) to an embedded program/erase engine.

A write is taken on the first clock in which chip enable and write enable are low and output enable is high. Address and data must be stable at that point. While the external engine reports busy, bus writes have no effect. While the identifier mode is active, the block supplies the byte a read at the current address would return: maker code, device code or the protection bit of a sector. Cell storage, pump control and pulse timing belong to other blocks.

Top module: `nor_cmd_decoder`

## Requirements
- R1: A write is accepted only when ce_n=0, we_n=0 and oe_n=1. It is accepted once per such low period, on its first clock. With oe_n low, or ce_n or we_n high, nothing is accepted.
- R2: Every command except return-to-read starts with AAh written at an address whose low 15 bits are 5555h, followed by 55h at low 15 bits 2AAAh. Bits above bit 14 are ignored. Any wrong address or data at a sequence step returns the decoder to read mode.
- R3: A third write of 90h at 5555h enters identifier mode. The mode output reads 1 and id_valid is high. id_data is 01h for address low byte 00h and 20h for low byte 01h. For low byte 02h it is prot_mask[addr[16:14]] in bit 0 with the upper bits zero. For any other byte it is 00h. Writes other than F0h are ignored in this mode.
- R4: A third write of A0h at 5555h arms programming. The next write, of any data including F0h, produces a one-cycle pgm_start in the following cycle, carrying that write's address and data on req_addr/req_data.
- R5: The sequence unlock, 80h, unlock, then 10h at 5555h produces erase_start with req_mask = FFh.
- R6: The sequence unlock, 80h, unlock, then 30h at any address sets bit addr[16:14] of the sector mask and opens an acceptance window of WIN_CYC cycles. The mode output reads 2 during the window.
- R7: Each further 30h write in the window adds its sector and restarts the window. If the window then runs out with no write, erase_start fires with the accumulated mask and the decoder returns to read mode.
- R8: Any other write in the window aborts it: no erase starts, and the collected mask is discarded.
- R9: F0h at any address returns to read mode from any sequence step, from identifier mode and from the window.
- R10: While eng_busy is high, the mode output reads 3, writes are ignored, the window timer is frozen and no start request is issued.
- R11: After reset, and in the cycle after lockout is high, the decoder is in read mode: mode 0, id_valid low, no start request.
- R12: pgm_start and erase_start are single-cycle pulses and are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lockout | input | 1 | Low-supply lockout; forces read mode |
| ce_n | input | 1 | Chip enable, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | 17 | Bus address |
| wdata | input | 8 | Bus write data |
| eng_busy | input | 1 | Embedded engine running |
| prot_mask | input | 8 | Per-sector protection status |
| mode | output | 2 | 0 read, 1 identifier, 2 erase window, 3 busy |
| id_valid | output | 1 | Identifier data is being supplied |
| id_data | output | 8 | Identifier read byte |
| pgm_start | output | 1 | Program request pulse |
| erase_start | output | 1 | Erase request pulse |
| req_addr | output | 17 | Program address |
| req_data | output | 8 | Program data |
| req_mask | output | 8 | Sectors to erase |

## Verification
The hardest situation to reach is the window retrigger. A second sector must arrive after more than half the window has passed, and the bench must then show that the erase did not start at the first deadline. The stimulus waits half the window after each 30h write and checks that the mode is still 2 past the first sector's original deadline. It then checks that the single erase request carries both sectors. A later abort, followed by a one-sector erase, shows that no stale mask bits carry over.

// File: rtl/nor_cmd_pkg.sv
package nor_cmd_pkg;
  typedef enum logic [3:0] {
    ST_READ, ST_UNL1, ST_UNL2, ST_PGM_ARM, ST_ERA0, ST_ERA1, ST_ERA2,
    ST_WINDOW, ST_IDENT
  } cmd_state_e;

  typedef enum logic [1:0] {
    MODE_READ = 2'd0, MODE_IDENT = 2'd1, MODE_WINDOW = 2'd2, MODE_BUSY = 2'd3
  } mode_e;

  localparam logic [14:0] UNLOCK_A1 = 15'h5555;
  localparam logic [14:0] UNLOCK_A2 = 15'h2AAA;
  localparam logic [7:0]  KEY1      = 8'hAA;
  localparam logic [7:0]  KEY2      = 8'h55;
  localparam logic [7:0]  OP_IDENT  = 8'h90;
  localparam logic [7:0]  OP_PGM    = 8'hA0;
  localparam logic [7:0]  OP_ERASE  = 8'h80;
  localparam logic [7:0]  OP_CHIP   = 8'h10;
  localparam logic [7:0]  OP_SECTOR = 8'h30;
  localparam logic [7:0]  OP_RESET  = 8'hF0;
endpackage

// File: rtl/nor_wr_detect.sv
module nor_wr_detect (
  input  logic clk,
  input  logic rst_n,
  input  logic ce_n,
  input  logic we_n,
  input  logic oe_n,
  output logic wr_evt
);
  logic wr_act;
  logic wr_q;

  assign wr_act = ~ce_n & ~we_n & oe_n;
  assign wr_evt = wr_act & ~wr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wr_q <= 1'b0;
    else        wr_q <= wr_act;
  end
endmodule

// File: rtl/nor_win_timer.sv
module nor_win_timer #(
  parameter int WIN_CYC = 12500
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic run,
  output logic expired
);
  localparam int TW = $clog2(WIN_CYC + 1);
  localparam logic [TW-1:0] LOAD_VAL = TW'(WIN_CYC - 1);

  logic [TW-1:0] cnt_q;
  logic [TW-1:0] cnt_d;
  logic          cnt_en;

  assign cnt_en  = load | (run & (cnt_q != '0));
  assign cnt_d   = load ? LOAD_VAL : cnt_q - 1'b1;
  assign expired = run & ~load & (cnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/nor_id_mux.sv
module nor_id_mux #(
  parameter int SEC_BITS = 3,
  parameter logic [7:0] MAKER_CODE = 8'h01,
  parameter logic [7:0] PART_CODE  = 8'h20
) (
  input  logic                      enable,
  input  logic [7:0]                low_byte,
  input  logic [SEC_BITS-1:0]       sector,
  input  logic [(1<<SEC_BITS)-1:0]  prot_mask,
  output logic [7:0]                id_byte
);
  always_comb begin
    id_byte = 8'h00;
    if (enable) begin
      unique case (low_byte)
        8'h00:   id_byte = MAKER_CODE;
        8'h01:   id_byte = PART_CODE;
        8'h02:   id_byte = {7'd0, prot_mask[sector]};
        default: id_byte = 8'h00;
      endcase
    end
  end
endmodule

// File: rtl/nor_cmd_decoder.sv
module nor_cmd_decoder #(
  parameter int AW       = 17,
  parameter int SEC_BITS = 3,
  parameter int WIN_CYC  = 12500
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     lockout,
  input  logic                     ce_n,
  input  logic                     we_n,
  input  logic                     oe_n,
  input  logic [AW-1:0]            addr,
  input  logic [7:0]               wdata,
  input  logic                     eng_busy,
  input  logic [(1<<SEC_BITS)-1:0] prot_mask,
  output logic [1:0]               mode,
  output logic                     id_valid,
  output logic [7:0]               id_data,
  output logic                     pgm_start,
  output logic                     erase_start,
  output logic [AW-1:0]            req_addr,
  output logic [7:0]               req_data,
  output logic [(1<<SEC_BITS)-1:0] req_mask
);
  import nor_cmd_pkg::*;

  localparam int NSEC = 1 << SEC_BITS;

  cmd_state_e        st_q, st_d;
  logic [NSEC-1:0]   mask_q, mask_d;
  logic              wr_evt, wr_ok;
  logic              win_load, win_exp;
  logic              pgm_d, era_d;
  logic [NSEC-1:0]   rmask_d;
  logic              req_en;
  logic [SEC_BITS-1:0] sec_idx;
  logic              at_a1, at_a2, is_reset;

  nor_wr_detect u_wr (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
    .wr_evt(wr_evt)
  );

  nor_win_timer #(.WIN_CYC(WIN_CYC)) u_win (
    .clk(clk), .rst_n(rst_n), .load(win_load),
    .run((st_q == ST_WINDOW) & ~eng_busy & ~lockout),
    .expired(win_exp)
  );

  nor_id_mux #(.SEC_BITS(SEC_BITS)) u_id (
    .enable(id_valid), .low_byte(addr[7:0]), .sector(sec_idx),
    .prot_mask(prot_mask), .id_byte(id_data)
  );

  assign wr_ok    = wr_evt & ~eng_busy;
  assign sec_idx  = addr[AW-1 -: SEC_BITS];
  assign at_a1    = addr[14:0] == UNLOCK_A1;
  assign at_a2    = addr[14:0] == UNLOCK_A2;
  assign is_reset = wdata == OP_RESET;

  // next-state logic
  always_comb begin
    st_d     = st_q;
    mask_d   = mask_q;
    pgm_d    = 1'b0;
    era_d    = 1'b0;
    rmask_d  = '0;
    win_load = 1'b0;
    if (lockout) begin
      st_d = ST_READ;
    end else if (wr_ok) begin
      st_d = ST_READ;
      unique case (st_q)
        ST_READ:    if (wdata == KEY1 && at_a1) st_d = ST_UNL1;
        ST_UNL1:    if (wdata == KEY2 && at_a2) st_d = ST_UNL2;
        ST_UNL2: begin
          if (at_a1 && wdata == OP_IDENT)      st_d = ST_IDENT;
          else if (at_a1 && wdata == OP_PGM)   st_d = ST_PGM_ARM;
          else if (at_a1 && wdata == OP_ERASE) st_d = ST_ERA0;
        end
        ST_PGM_ARM: pgm_d = 1'b1;
        ST_ERA0:    if (wdata == KEY1 && at_a1) st_d = ST_ERA1;
        ST_ERA1:    if (wdata == KEY2 && at_a2) st_d = ST_ERA2;
        ST_ERA2: begin
          if (at_a1 && wdata == OP_CHIP) begin
            era_d   = 1'b1;
            rmask_d = '1;
          end else if (wdata == OP_SECTOR) begin
            st_d     = ST_WINDOW;
            win_load = 1'b1;
            mask_d[sec_idx] = 1'b1;
          end
        end
        ST_WINDOW: begin
          if (wdata == OP_SECTOR) begin
            st_d     = ST_WINDOW;
            win_load = 1'b1;
            mask_d[sec_idx] = 1'b1;
          end
        end
        ST_IDENT:   if (!is_reset) st_d = ST_IDENT;
        default:    st_d = ST_READ;
      endcase
    end else if (win_exp) begin
      st_d    = ST_READ;
      era_d   = 1'b1;
      rmask_d = mask_q;
    end
    if (st_d == ST_READ) mask_d = '0;
  end

  assign req_en = pgm_d | era_d;

  // state registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q        <= ST_READ;
      mask_q      <= '0;
      pgm_start   <= 1'b0;
      erase_start <= 1'b0;
    end else begin
      st_q        <= st_d;
      mask_q      <= mask_d;
      pgm_start   <= pgm_d;
      erase_start <= era_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_addr <= '0;
      req_data <= '0;
      req_mask <= '0;
    end else if (req_en) begin
      req_addr <= pgm_d ? addr  : '0;
      req_data <= pgm_d ? wdata : '0;
      req_mask <= rmask_d;
    end
  end

  assign id_valid = (st_q == ST_IDENT);

  always_comb begin
    if (eng_busy)               mode = MODE_BUSY;
    else if (st_q == ST_IDENT)  mode = MODE_IDENT;
    else if (st_q == ST_WINDOW) mode = MODE_WINDOW;
    else                        mode = MODE_READ;
  end
endmodule

// File: rtl/nor_cmd_decoder_chk.sv
module nor_cmd_decoder_chk #(
  parameter int AW = 17,
  parameter int SEC_BITS = 3
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     lockout,
  input logic                     eng_busy,
  input logic                     id_valid,
  input logic                     pgm_start,
  input logic                     erase_start,
  input logic [(1<<SEC_BITS)-1:0] req_mask
);
  AST_NO_DUAL_START: assert property (@(posedge clk) disable iff (!rst_n)
    !(pgm_start && erase_start)); // R12

  AST_PGM_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    pgm_start |=> !pgm_start); // R12

  AST_BUSY_NO_START: assert property (@(posedge clk) disable iff (!rst_n)
    $past(eng_busy) |-> (!pgm_start && !erase_start)); // R10

  AST_LOCKOUT_READ: assert property (@(posedge clk) disable iff (!rst_n)
    $past(lockout) |-> (!id_valid && !pgm_start && !erase_start)); // R11

  AST_ERASE_HAS_SECTOR: assert property (@(posedge clk) disable iff (!rst_n)
    erase_start |-> (req_mask != '0)); // R7
endmodule

bind nor_cmd_decoder nor_cmd_decoder_chk #(.AW(AW), .SEC_BITS(SEC_BITS)) u_chk (
  .clk(clk), .rst_n(rst_n), .lockout(lockout), .eng_busy(eng_busy),
  .id_valid(id_valid), .pgm_start(pgm_start), .erase_start(erase_start),
  .req_mask(req_mask)
);

// File: tb/nor_cmd_decoder_test.sv
module nor_cmd_decoder_test;
  localparam int WIN = 40;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        lockout = 1'b0;
  logic        ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
  logic [16:0] addr = '0;
  logic [7:0]  wdata = '0;
  logic        eng_busy = 1'b0;
  logic [7:0]  prot_mask = 8'b0010_0000;
  logic [1:0]  mode;
  logic        id_valid, pgm_start, erase_start;
  logic [7:0]  id_data, req_data, req_mask;
  logic [16:0] req_addr;

  int total = 0;
  int bad = 0;
  bit prev_pgm = 1'b0;

  typedef struct packed {
    logic        is_erase;
    logic [16:0] a;
    logic [7:0]  d;
    logic [7:0]  m;
  } item_t;
  item_t expq[$];

  always #2 clk = ~clk;

  nor_cmd_decoder #(.WIN_CYC(WIN)) uut (
    .clk(clk), .rst_n(rst_n), .lockout(lockout), .ce_n(ce_n), .we_n(we_n),
    .oe_n(oe_n), .addr(addr), .wdata(wdata), .eng_busy(eng_busy),
    .prot_mask(prot_mask), .mode(mode), .id_valid(id_valid), .id_data(id_data),
    .pgm_start(pgm_start), .erase_start(erase_start), .req_addr(req_addr),
    .req_data(req_data), .req_mask(req_mask)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [16:0] a, input logic [7:0] d,
                        input logic c = 1'b0, input logic w = 1'b0, input logic o = 1'b1);
    @(negedge clk);
    addr = a; wdata = d; ce_n = c; we_n = w; oe_n = o;
    @(negedge clk);
    @(negedge clk);
    ce_n = 1'b1; we_n = 1'b1; oe_n = 1'b1;
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic unlock();
    bus_wr(17'h05555, 8'hAA);
    bus_wr(17'h02AAA, 8'h55);
  endtask

  task automatic push(input logic e, input logic [16:0] a, input logic [7:0] d, input logic [7:0] m);
    item_t it;
    it.is_erase = e; it.a = a; it.d = d; it.m = m;
    expq.push_back(it);
  endtask

  task automatic read_id(input logic [16:0] a, input logic [7:0] exp);
    @(negedge clk);
    addr = a; oe_n = 1'b0; ce_n = 1'b0;
    @(negedge clk);
    check("R3 id_data", {24'd0, id_data}, {24'd0, exp});
    oe_n = 1'b1; ce_n = 1'b1;
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n) begin
      if (pgm_start && prev_pgm) begin
        total++; bad++;
        $display("FAIL R12 pgm_start wider than one cycle actual=1 expected=0");
      end
      if (pgm_start || erase_start) begin
        total++;
        if (expq.size() == 0) begin
          bad++;
          $display("FAIL R4/R7 unexpected start actual=pgm%0d/era%0d expected=none",
                   pgm_start, erase_start);
        end else begin
          item_t e;
          e = expq.pop_front();
          if (e.is_erase) begin
            if (!(erase_start && !pgm_start && req_mask == e.m)) begin
              bad++;
              $display("FAIL R5/R7 erase actual=era%0d mask=%0h expected=mask=%0h",
                       erase_start, req_mask, e.m);
            end
          end else if (!(pgm_start && !erase_start && req_addr == e.a && req_data == e.d)) begin
            bad++;
            $display("FAIL R4 program actual=%0h/%0h expected=%0h/%0h",
                     req_addr, req_data, e.a, e.d);
          end
        end
      end
      prev_pgm = pgm_start;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    check("R11 mode after reset", {30'd0, mode}, 32'd0);
    check("R11 id_valid after reset", {31'd0, id_valid}, 32'd0);

    // R1 gated writes are not accepted
    bus_wr(17'h05555, 8'hAA, 1'b0, 1'b0, 1'b0);
    bus_wr(17'h02AAA, 8'h55);
    bus_wr(17'h05555, 8'h90);
    check("R1 oe low blocks write", {31'd0, id_valid}, 32'd0);
    bus_wr(17'h05555, 8'hAA, 1'b1, 1'b0, 1'b1);
    bus_wr(17'h02AAA, 8'h55);
    bus_wr(17'h05555, 8'h90);
    check("R1 ce high blocks write", {31'd0, id_valid}, 32'd0);

    // R2 upper address bits ignored; R3 identifier mode
    bus_wr(17'h1D555, 8'hAA);
    bus_wr(17'h0AAAA, 8'h55);
    bus_wr(17'h15555, 8'h90);
    check("R3 enter identifier", {31'd0, id_valid}, 32'd1);
    check("R3 mode identifier", {30'd0, mode}, 32'd1);
    read_id(17'h00000, 8'h01);
    read_id(17'h12301, 8'h20);
    read_id(17'h14002, 8'h01);
    read_id(17'h08002, 8'h00);
    read_id(17'h00003, 8'h00);
    bus_wr(17'h05555, 8'hAA);
    check("R3 non-reset write ignored", {31'd0, id_valid}, 32'd1);
    bus_wr(17'h1ABCD, 8'hF0);
    check("R9 reset leaves identifier", {31'd0, id_valid}, 32'd0);

    // R4 programming, including an F0h data byte
    unlock(); bus_wr(17'h05555, 8'hA0);
    push(1'b0, 17'h12345, 8'h3C, 8'h00);
    bus_wr(17'h12345, 8'h3C);
    unlock(); bus_wr(17'h05555, 8'hA0);
    push(1'b0, 17'h00777, 8'hF0, 8'h00);
    bus_wr(17'h00777, 8'hF0);
    check("R4 back to read", {30'd0, mode}, 32'd0);

    // R2 wrong unlock address drops to read; following write is not program data
    bus_wr(17'h05555, 8'hAA);
    bus_wr(17'h02AAB, 8'h55);
    bus_wr(17'h05555, 8'hA0);
    bus_wr(17'h00100, 8'h77);
    check("R2 wrong step no start", expq.size(), 32'd0);

    // R9 reset between unlock cycles
    bus_wr(17'h05555, 8'hAA);
    bus_wr(17'h00000, 8'hF0);
    bus_wr(17'h02AAA, 8'h55);
    bus_wr(17'h05555, 8'h90);
    check("R9 reset mid-sequence", {31'd0, id_valid}, 32'd0);

    // R5 whole-array erase
    unlock(); bus_wr(17'h05555, 8'h80); unlock();
    push(1'b1, '0, '0, 8'hFF);
    bus_wr(17'h05555, 8'h10);
    check("R5 chip erase issued", expq.size(), 32'd0);

    // R6/R7 window with retrigger
    unlock(); bus_wr(17'h05555, 8'h80); unlock();
    bus_wr(17'h0C000, 8'h30);
    check("R6 window mode", {30'd0, mode}, 32'd2);
    repeat (WIN/2) @(negedge clk);
    bus_wr(17'h18010, 8'h30);
    push(1'b1, '0, '0, 8'h48);
    repeat (WIN/2) @(negedge clk);
    check("R7 window restarted", {30'd0, mode}, 32'd2);
    repeat (WIN) @(negedge clk);
    check("R7 erase after window", expq.size(), 32'd0);
    check("R7 read after erase", {30'd0, mode}, 32'd0);

    // R8 abort, then fresh mask
    unlock(); bus_wr(17'h05555, 8'h80); unlock();
    bus_wr(17'h04000, 8'h30);
    bus_wr(17'h05555, 8'h80);
    check("R8 abort to read", {30'd0, mode}, 32'd0);
    repeat (WIN + 4) @(negedge clk);
    check("R8 no erase after abort", expq.size(), 32'd0);
    unlock(); bus_wr(17'h05555, 8'h80); unlock();
    push(1'b1, '0, '0, 8'h80);
    bus_wr(17'h1C000, 8'h30);
    repeat (WIN + 4) @(negedge clk);
    check("R8 mask cleared", expq.size(), 32'd0);

    // R10 busy blocks writes
    @(negedge clk); eng_busy = 1'b1;
    @(negedge clk);
    check("R10 busy mode", {30'd0, mode}, 32'd3);
    unlock(); bus_wr(17'h05555, 8'hA0); bus_wr(17'h00040, 8'h11);
    @(negedge clk); eng_busy = 1'b0;
    @(negedge clk);
    check("R10 mode after busy", {30'd0, mode}, 32'd0);
    bus_wr(17'h00041, 8'h22);
    check("R10 no program from busy writes", expq.size(), 32'd0);

    // R11 lockout
    unlock(); bus_wr(17'h05555, 8'h90);
    check("R11 identifier before lockout", {31'd0, id_valid}, 32'd1);
    @(negedge clk); lockout = 1'b1;
    @(negedge clk); lockout = 1'b0;
    check("R11 lockout to read", {31'd0, id_valid}, 32'd0);
    check("R11 lockout mode", {30'd0, mode}, 32'd0);

    repeat (4) @(negedge clk);
    check("R12 scoreboard drained", expq.size(), 32'd0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule